// File: doc/BRIEF.md
# Dual-Slot Clock Source Reprogrammer

This block retunes a processor clock without the clock ever running from a partly written setting. The clock control register holds two complete source/divider slots, and one bit of a small select register says which slot drives the clock. A change request carries a 3-bit source select, a 4-bit source divider and a 2-bit bus clock divider. The block writes the new source and then the new divider into whichever slot is idle, and only then flips the select bit, so the switch happens in one register write.

The bus clock divider lives in the select register beside the slot bit. When the new bus divider is larger (slower bus) it is written before the flip. When it is smaller it is written after the flip. When it is unchanged it is not written. This keeps the bus clock from ever running faster than the processor clock allows. Before each sequence a wait-state count in the control register is loaded with a fixed value. Each step is one register write per clock. `busy` covers the whole sequence and `done` pulses once at its end. Both register images and the active slot's source and divider are visible as outputs for the clock mux downstream.

Top module: `clk_slot_reprog`

## Requirements
- R1: After reset `ctrl_reg` and `sel_reg` are all zero (slot 0 active, bus divider 0), `busy` and `done` are low.
- R2: A request accepted at a clock edge loads the wait-state field `ctrl_reg[23:16]` with WAIT_LOAD (default 100) at that same edge, before any slot or bus field changes. The field keeps that value afterwards.
- R3: The new source and divider go only into the inactive slot. Slot 0 holds source at `ctrl_reg[14:12]` and divider at `ctrl_reg[11:8]`. Slot 1 holds source at `ctrl_reg[6:4]` and divider at `ctrl_reg[3:0]`. The source is written at the 3rd edge counting the accepting edge as the 1st, and the divider at the 4th. The active slot's fields never change during a sequence.
- R4: `sel_reg[0]` (0 = slot 0 active, 1 = slot 1 active) toggles exactly once per request, at the 5th edge, after both slot fields are written.
- R5: If the requested bus divider is larger than `sel_reg[2:1]`, it is written at the 2nd edge, before the flip.
- R6: If the requested bus divider is smaller than `sel_reg[2:1]`, it is written at the 6th edge, after the flip.
- R7: If the requested bus divider equals `sel_reg[2:1]`, that field is not written and stays unchanged throughout.
- R8: `busy` is high from the accepting edge until the 7th edge. `done` is high for exactly one cycle, between the 6th and 7th edges.
- R9: `req_valid` and request data are ignored while `busy` is high. The final register contents reflect only the accepted request.
- R10: `cur_src` and `cur_div` always show the source and divider fields of the slot selected by `sel_reg[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Change request, accepted when idle |
| req_src | input | 3 | Target source select |
| req_div | input | 4 | Target source divider |
| req_bus | input | 2 | Target bus clock divider |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| ctrl_reg | output | 24 | Control register image: wait count and both slots |
| sel_reg | output | 3 | Select register image: bus divider and active slot |
| cur_src | output | 3 | Source select of the active slot |
| cur_div | output | 4 | Divider of the active slot |

## Verification
The bench uses the default field widths and WAIT_LOAD of 100. At these sizes every combination of source select, source divider and a cycling bus divider can be requested, with the active slot alternating each time. A second pass walks all sixteen ordered pairs of old and new bus divider, so the grow, shrink and equal orderings are each reached from every start value. Every cycle of each sequence is compared with an arithmetic model of the register images. On a quarter of the requests, conflicting request data is held on the inputs for the whole sequence.

// File: rtl/clk_slot_pkg.sv
package clk_slot_pkg;

    localparam int SRC_W        = 3;
    localparam int DIV_W        = 4;
    localparam int BUS_W        = 2;
    localparam int WAIT_W       = 8;
    localparam int NSLOT        = 2;
    localparam int WAIT_LSB     = 16;
    localparam int CTRL_W       = WAIT_LSB + WAIT_W;
    localparam int SEL_SLOT_BIT = 0;
    localparam int SEL_BUS_LSB  = 1;
    localparam int SEL_W        = SEL_BUS_LSB + BUS_W;

    typedef logic [SRC_W-1:0]  src_t;
    typedef logic [DIV_W-1:0]  div_t;
    typedef logic [BUS_W-1:0]  bus_t;
    typedef logic [WAIT_W-1:0] wait_t;

    typedef struct packed {
        src_t src;
        div_t div;
        bus_t bus;
    } req_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PRE_DIV, ST_WR_SRC, ST_WR_DIV, ST_FLIP, ST_POST_DIV, ST_DONE
    } seq_state_t;

    typedef enum logic [2:0] {
        OP_NONE, OP_WAIT, OP_BUS, OP_SRC, OP_DIV, OP_FLIP
    } wr_op_t;

    typedef enum logic [1:0] {
        BUS_KEEP, BUS_BEFORE, BUS_AFTER
    } bus_order_t;

    typedef struct packed {
        wr_op_t op;
        req_t   val;
    } wr_cmd_t;

    // Field positions inside the control register; slot 0 sits high.
    function automatic int slot_src_lsb(input int s);
        return (s == 0) ? 12 : 4;
    endfunction

    function automatic int slot_div_lsb(input int s);
        return (s == 0) ? 8 : 0;
    endfunction

    // Slower bus first, faster bus only after the core clock has moved.
    function automatic bus_order_t pick_bus_order(input bus_t nxt, input bus_t cur);
        if (nxt > cur)      return BUS_BEFORE;
        else if (nxt < cur) return BUS_AFTER;
        else                return BUS_KEEP;
    endfunction

endpackage

// File: rtl/clk_slot_seq.sv
module clk_slot_seq
    import clk_slot_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    req_valid,
    input  req_t    req,
    input  bus_t    cur_bus,
    output wr_cmd_t cmd,
    output logic    busy,
    output logic    done
);

    seq_state_t state_q;
    req_t       tgt_q;
    bus_order_t order_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            tgt_q   <= '0;
            order_q <= BUS_KEEP;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        tgt_q   <= req;
                        order_q <= pick_bus_order(req.bus, cur_bus);
                        state_q <= ST_PRE_DIV;
                    end
                end
                ST_PRE_DIV:  state_q <= ST_WR_SRC;
                ST_WR_SRC:   state_q <= ST_WR_DIV;
                ST_WR_DIV:   state_q <= ST_FLIP;
                ST_FLIP:     state_q <= ST_POST_DIV;
                ST_POST_DIV: state_q <= ST_DONE;
                ST_DONE:     state_q <= ST_IDLE;
                default:     state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        cmd.op  = OP_NONE;
        cmd.val = tgt_q;
        unique case (state_q)
            ST_IDLE:     if (req_valid) cmd.op = OP_WAIT;
            ST_PRE_DIV:  if (order_q == BUS_BEFORE) cmd.op = OP_BUS;
            ST_WR_SRC:   cmd.op = OP_SRC;
            ST_WR_DIV:   cmd.op = OP_DIV;
            ST_FLIP:     cmd.op = OP_FLIP;
            ST_POST_DIV: if (order_q == BUS_AFTER) cmd.op = OP_BUS;
            default:     cmd.op = OP_NONE;
        endcase
    end

    assign busy = (state_q != ST_IDLE);
    assign done = (state_q == ST_DONE);

    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    a_r9_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

endmodule

// File: rtl/clk_slot_regs.sv
module clk_slot_regs
    import clk_slot_pkg::*;
#(
    parameter int WAIT_LOAD = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_cmd_t           cmd,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [SEL_W-1:0]  sel_o,
    output src_t              cur_src,
    output div_t              cur_div,
    output bus_t              cur_bus
);

    localparam wait_t WAIT_VAL = wait_t'(WAIT_LOAD);

    logic  slot_q;
    bus_t  bus_q;
    wait_t wait_q;
    src_t  src_a [NSLOT];
    div_t  div_a [NSLOT];

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= 1'b0;
            bus_q  <= '0;
            wait_q <= '0;
        end else begin
            if (cmd.op == OP_WAIT) wait_q <= WAIT_VAL;
            if (cmd.op == OP_BUS)  bus_q  <= cmd.val.bus;
            if (cmd.op == OP_FLIP) slot_q <= ~slot_q;
        end
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        src_t src_q;
        div_t div_q;
        wire  idle_slot = (slot_q != 1'(s));

        always_ff @(posedge clk) begin
            if (rst) begin
                src_q <= '0;
                div_q <= '0;
            end else begin
                if (cmd.op == OP_SRC && idle_slot) src_q <= cmd.val.src;
                if (cmd.op == OP_DIV && idle_slot) div_q <= cmd.val.div;
            end
        end

        assign src_a[s] = src_q;
        assign div_a[s] = div_q;
    end

    always_comb begin
        ctrl_o = '0;
        ctrl_o[WAIT_LSB +: WAIT_W] = wait_q;
        for (int s = 0; s < NSLOT; s++) begin
            ctrl_o[slot_src_lsb(s) +: SRC_W] = src_a[s];
            ctrl_o[slot_div_lsb(s) +: DIV_W] = div_a[s];
        end
        sel_o = '0;
        sel_o[SEL_SLOT_BIT]         = slot_q;
        sel_o[SEL_BUS_LSB +: BUS_W] = bus_q;
    end

    assign cur_src = src_a[slot_q];
    assign cur_div = div_a[slot_q];
    assign cur_bus = bus_q;

    a_r3_active_untouched: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == OP_SRC || cmd.op == OP_DIV) |=> ($stable(cur_src) && $stable(cur_div)));

endmodule

// File: rtl/clk_slot_reprog.sv
module clk_slot_reprog
    import clk_slot_pkg::*;
#(
    parameter int WAIT_LOAD = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [SRC_W-1:0]  req_src,
    input  logic [DIV_W-1:0]  req_div,
    input  logic [BUS_W-1:0]  req_bus,
    output logic              busy,
    output logic              done,
    output logic [CTRL_W-1:0] ctrl_reg,
    output logic [SEL_W-1:0]  sel_reg,
    output logic [SRC_W-1:0]  cur_src,
    output logic [DIV_W-1:0]  cur_div
);

    req_t    req;
    wr_cmd_t cmd;
    bus_t    cur_bus;

    assign req = '{src: req_src, div: req_div, bus: req_bus};

    clk_slot_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req       (req),
        .cur_bus   (cur_bus),
        .cmd       (cmd),
        .busy      (busy),
        .done      (done)
    );

    clk_slot_regs #(.WAIT_LOAD(WAIT_LOAD)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .ctrl_o  (ctrl_reg),
        .sel_o   (sel_reg),
        .cur_src (cur_src),
        .cur_div (cur_div),
        .cur_bus (cur_bus)
    );

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (!busy && !req_valid) |=> ($stable(ctrl_reg) && $stable(sel_reg)));

    a_r4_flip_in_sequence: assert property (@(posedge clk) disable iff (rst)
        (!busy) |=> ($stable(sel_reg[SEL_SLOT_BIT]) && $stable(ctrl_reg[SEL_W+12-SEL_W +: SRC_W])));

    a_r5_r6_bus_apart_from_flip: assert property (@(posedge clk) disable iff (rst)
        !$stable(sel_reg[SEL_BUS_LSB +: BUS_W]) |-> $stable(sel_reg[SEL_SLOT_BIT]));

endmodule

// File: tb/clk_slot_reprog_test.sv
module clk_slot_reprog_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_src = '0;
    logic [3:0]  req_div = '0;
    logic [1:0]  req_bus = '0;
    logic        busy, done;
    logic [23:0] ctrl_reg;
    logic [2:0]  sel_reg;
    logic [2:0]  cur_src;
    logic [3:0]  cur_div;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    // Bench model of register contents.
    int m_slot, m_bus, m_wait;
    int m_src [2];
    int m_div [2];

    clk_slot_reprog uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_src(req_src),
        .req_div(req_div), .req_bus(req_bus), .busy(busy), .done(done),
        .ctrl_reg(ctrl_reg), .sel_reg(sel_reg), .cur_src(cur_src), .cur_div(cur_div)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int pack_ctrl(input int w, input int s0s, input int s0d,
                                     input int s1s, input int s1d);
        return (w << 16) | (s0s << 12) | (s0d << 8) | (s1s << 4) | s1d;
    endfunction

    task automatic run_req(input int src, input int dv, input int bus, input bit hold);
        int ns, exp_bus, exp_slot, exp_ctrl;
        int e_src [2];
        int e_div [2];
        ns = 1 - m_slot;
        @(negedge clk);
        req_valid = 1'b1; req_src = 3'(src); req_div = 4'(dv); req_bus = 2'(bus);
        @(posedge clk);
        for (int j = 0; j <= 6; j++) begin
            @(negedge clk);
            if (hold) begin
                req_src = 3'(~src); req_div = 4'(~dv); req_bus = 2'(~bus);
                if (j == 5) req_valid = 1'b0;
            end else if (j == 0) begin
                req_valid = 1'b0;
            end
            e_src = m_src; e_div = m_div;
            if (j >= 2) e_src[ns] = src;
            if (j >= 3) e_div[ns] = dv;
            exp_slot = (j >= 4) ? ns : m_slot;
            exp_bus  = m_bus;
            if (bus > m_bus && j >= 1) exp_bus = bus;
            if (bus < m_bus && j >= 5) exp_bus = bus;
            exp_ctrl = pack_ctrl(100, e_src[0], e_div[0], e_src[1], e_div[1]);
            chk(ctrl_reg[23:16] == 8'd100, "R2 wait field", int'(ctrl_reg[23:16]), 100);
            chk(int'(ctrl_reg) == exp_ctrl, hold ? "R9 ctrl image under held request" : "R3 ctrl image",
                int'(ctrl_reg), exp_ctrl);
            chk(int'(sel_reg[0]) == exp_slot, "R4 active slot bit", int'(sel_reg[0]), exp_slot);
            chk(int'(sel_reg[2:1]) == exp_bus,
                (bus > m_bus) ? "R5 bus grow order" : (bus < m_bus) ? "R6 bus shrink order" : "R7 bus equal",
                int'(sel_reg[2:1]), exp_bus);
            chk(done == (j == 5), "R8 done pulse", int'(done), int'(j == 5));
            chk(busy == (j <= 5), "R8 busy window", int'(busy), int'(j <= 5));
            chk(int'(cur_src) == e_src[exp_slot], "R10 cur_src", int'(cur_src), e_src[exp_slot]);
            chk(int'(cur_div) == e_div[exp_slot], "R10 cur_div", int'(cur_div), e_div[exp_slot]);
        end
        m_src[ns] = src; m_div[ns] = dv; m_slot = ns; m_bus = bus; m_wait = 100;
    endtask

    initial begin
        m_slot = 0; m_bus = 0; m_wait = 0;
        m_src[0] = 0; m_src[1] = 0; m_div[0] = 0; m_div[1] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(ctrl_reg == '0, "R1 ctrl reset", int'(ctrl_reg), 0);
        chk(sel_reg == '0, "R1 sel reset", int'(sel_reg), 0);
        chk(!busy && !done, "R1 busy/done reset", int'({busy, done}), 0);
        // R9 idle stability: nothing moves without a request
        repeat (3) @(negedge clk);
        chk(ctrl_reg == '0 && sel_reg == '0, "R9 idle no change", int'(ctrl_reg), 0);

        for (int i = 0; i < 512; i++)
            run_req(i[4:2], i[8:5], i[1:0], (i % 4) == 2);

        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++) begin
                run_req((a + b) % 8, (a * 4 + b) % 16, a, 1'b0);
                run_req((a * b) % 8, (15 - a - b), b, 1'b0);
            end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule